// File: doc/BRIEF.md
# Inhibit-Frozen Position Latch with Byte-Lane Readout

This block sits at the output of a tracking position converter. A position counter outside the block runs all the time, and its value arrives here every clock. A holding register copies that value on every clock while the hold request `inhibit` is low. While `inhibit` is high the register keeps its contents. The counter is never stopped, so when the hold is released the register follows the live position again at the very next edge, with no reacquisition period.

Software reads the held word through two active-low lane enables. `msb_en_n` selects the upper byte (bits 15..8) and `lsb_en_n` selects the lower byte (bits 7..0). The parameter `WIDE_BUS` sets the bus width:
- With `WIDE_BUS = 0` the bus is 8 bits wide, and the two bytes take turns on the same lines.
- With `WIDE_BUS = 1` the bus is 16 bits wide, and the whole word appears at once with its most significant bit on line 15.

A per-bit output-enable vector stands in for tri-state drivers. The enables act combinationally. `rd_valid` rises a fixed number of clocks (`VALID_DLY`, at least 1) after the hold takes effect. This tells the reader that both bytes come from one frozen sample.

The hold controller is a state machine with three states:
- TRACK: the register follows the position.
- SETTLE: the register is held and the delay counter runs.
- FROZEN: the register is held and `rd_valid` is high.

Its transitions are:
- TRACK to SETTLE when `inhibit` is sampled high. If `VALID_DLY` is 1, this step goes straight from TRACK to FROZEN.
- SETTLE to FROZEN when the delay count ends.
- SETTLE to TRACK, and FROZEN to TRACK, when `inhibit` is sampled low.
- Reset goes to TRACK.

Top module: `pos_latch_readout`

## Requirements
- R1: After reset, the holding register is 0, `rd_valid` is 0 and the controller is in TRACK.
- R2: At every clock edge where `inhibit` is low, the holding register loads `pos_in`.
- R3: At every clock edge where `inhibit` is high, the holding register keeps its value. `pos_in` keeps changing and has no effect, however long the hold lasts.
- R4: `rd_valid` goes to 1 at the `VALID_DLY`-th consecutive edge that samples `inhibit` high. It stays 1 while `inhibit` stays high. It goes to 0 at the first edge that samples `inhibit` low. A hold shorter than `VALID_DLY` edges never raises it.
- R5: After a hold, the first edge with `inhibit` low loads the live `pos_in`. No extra cycles are needed.
- R6: On the 8-bit bus (`WIDE_BUS = 0`), `msb_en_n` low drives register bits 15..8 onto `bus_data[7:0]` with `bus_oe` = 8'hFF.
- R7: On the 8-bit bus, when only `lsb_en_n` is low, register bits 7..0 are driven onto `bus_data[7:0]` with `bus_oe` = 8'hFF.
- R8: On the 8-bit bus, when both enables are low, the upper byte is driven and `lane_err` is 1. Otherwise `lane_err` is 0.
- R9: On the 16-bit bus (`WIDE_BUS = 1`), `msb_en_n` low drives bits 15..8 onto `bus_data[15:8]`, and `lsb_en_n` low drives bits 7..0 onto `bus_data[7:0]`. Each byte sets its own eight `bus_oe` bits. `lane_err` is always 0.
- R10: Every bus line whose lane is not enabled has `bus_oe` = 0 and `bus_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_in | input | POS_W (16) | Live value of the free-running position counter |
| inhibit | input | 1 | Hold request; high freezes the holding register |
| msb_en_n | input | 1 | Active-low enable for the upper byte lane |
| lsb_en_n | input | 1 | Active-low enable for the lower byte lane |
| bus_data | output | BUS_W (8 or 16) | Bus data; 0 on lines that are not driven |
| bus_oe | output | BUS_W (8 or 16) | Per-line drive enable (1 = driven, 0 = high impedance) |
| rd_valid | output | 1 | The held word is stable and may be read |
| lane_err | output | 1 | Both lanes are requested at once on the 8-bit bus |

## Verification
Two functions can fall in the same cycle: the freeze of the holding register on the first edge that samples `inhibit` high, and a byte read. The bench holds a lane enable low across that edge while `pos_in` keeps stepping. It also reads the two bytes alternately during a long hold. Each read must show the value captured on the last edge with `inhibit` low, never the live count. This is judged on every clock against a behavioural model of the register and of the hold-edge count, for both bus widths in parallel. Short holds, releases and enable conflicts are mixed in the same way.

// File: rtl/pos_latch_pkg.sv
package pos_latch_pkg;
    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_FROZEN = 2'd2
    } hold_state_t;
endpackage

// File: rtl/pos_hold_fsm.sv
module pos_hold_fsm
    import pos_latch_pkg::*;
#(
    parameter int POS_W     = 16,
    parameter int VALID_DLY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inhibit,
    input  logic [POS_W-1:0] pos_in,
    output logic [POS_W-1:0] hold_q,
    output logic             rd_valid
);
    localparam int CNT_W = (VALID_DLY < 2) ? 1 : $clog2(VALID_DLY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(VALID_DLY - 1);

    hold_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_TRACK: begin
                if (inhibit) begin
                    if (VALID_DLY <= 1) begin
                        state_d = ST_FROZEN;
                    end else begin
                        state_d = ST_SETTLE;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            ST_SETTLE: begin
                if (!inhibit) begin
                    state_d = ST_TRACK;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_FROZEN;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_FROZEN: begin
                if (!inhibit) begin
                    state_d = ST_TRACK;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_TRACK;
                cnt_d   = '0;
            end
        endcase
    end

    // state register together with the holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (!inhibit) begin
                hold_q <= pos_in;
            end
        end
    end

    // outputs
    always_comb begin
        rd_valid = (state_q == ST_FROZEN);
    end
endmodule

// File: rtl/pos_lane_mux.sv
module pos_lane_mux #(
    parameter int POS_W    = 16,
    parameter bit WIDE_BUS = 1'b0,
    localparam int LANE_W  = POS_W / 2,
    localparam int BUS_W   = WIDE_BUS ? POS_W : LANE_W
) (
    input  logic [POS_W-1:0] hold_q,
    input  logic             msb_en_n,
    input  logic             lsb_en_n,
    output logic [BUS_W-1:0] bus_data,
    output logic [BUS_W-1:0] bus_oe,
    output logic             lane_err
);
    logic [LANE_W-1:0] hi_byte, lo_byte;

    assign hi_byte = hold_q[POS_W-1:LANE_W];
    assign lo_byte = hold_q[LANE_W-1:0];

    generate
        if (WIDE_BUS) begin : g_wide
            always_comb begin
                bus_data = {(msb_en_n ? {LANE_W{1'b0}} : hi_byte),
                            (lsb_en_n ? {LANE_W{1'b0}} : lo_byte)};
                bus_oe   = {{LANE_W{~msb_en_n}}, {LANE_W{~lsb_en_n}}};
                lane_err = 1'b0;
            end
        end else begin : g_narrow
            always_comb begin
                lane_err = !msb_en_n && !lsb_en_n;
                if (!msb_en_n) begin
                    bus_data = hi_byte;
                    bus_oe   = '1;
                end else if (!lsb_en_n) begin
                    bus_data = lo_byte;
                    bus_oe   = '1;
                end else begin
                    bus_data = '0;
                    bus_oe   = '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pos_latch_readout.sv
module pos_latch_readout #(
    parameter int POS_W     = 16,
    parameter bit WIDE_BUS  = 1'b0,
    parameter int VALID_DLY = 3,
    localparam int BUS_W    = WIDE_BUS ? POS_W : POS_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_in,
    input  logic             inhibit,
    input  logic             msb_en_n,
    input  logic             lsb_en_n,
    output logic [BUS_W-1:0] bus_data,
    output logic [BUS_W-1:0] bus_oe,
    output logic             rd_valid,
    output logic             lane_err
);
    logic [POS_W-1:0] hold_w;

    pos_hold_fsm #(
        .POS_W     (POS_W),
        .VALID_DLY (VALID_DLY)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .inhibit  (inhibit),
        .pos_in   (pos_in),
        .hold_q   (hold_w),
        .rd_valid (rd_valid)
    );

    pos_lane_mux #(
        .POS_W    (POS_W),
        .WIDE_BUS (WIDE_BUS)
    ) u_mux (
        .hold_q   (hold_w),
        .msb_en_n (msb_en_n),
        .lsb_en_n (lsb_en_n),
        .bus_data (bus_data),
        .bus_oe   (bus_oe),
        .lane_err (lane_err)
    );
endmodule

// File: rtl/pos_latch_readout_chk.sv
module pos_latch_readout_chk #(
    parameter int POS_W    = 16,
    parameter bit WIDE_BUS = 1'b0,
    localparam int BUS_W   = WIDE_BUS ? POS_W : POS_W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [POS_W-1:0] pos_in,
    input logic             inhibit,
    input logic             msb_en_n,
    input logic             lsb_en_n,
    input logic [POS_W-1:0] hold_w,
    input logic [BUS_W-1:0] bus_data,
    input logic [BUS_W-1:0] bus_oe,
    input logic             rd_valid,
    input logic             lane_err
);
    p_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !inhibit) |=> (hold_w == $past(pos_in)));

    p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && inhibit) |=> $stable(hold_w));

    p_valid_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !inhibit) |=> !rd_valid);

    p_valid_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(inhibit));

    p_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!WIDE_BUS && !msb_en_n && !lsb_en_n) |->
            (lane_err && (bus_data == hold_w[POS_W-1:POS_W-BUS_W])));

    p_idle_lanes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msb_en_n && lsb_en_n) |-> ((bus_oe == '0) && (bus_data == '0)));
endmodule

bind pos_latch_readout pos_latch_readout_chk #(
    .POS_W    (POS_W),
    .WIDE_BUS (WIDE_BUS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos_in   (pos_in),
    .inhibit  (inhibit),
    .msb_en_n (msb_en_n),
    .lsb_en_n (lsb_en_n),
    .hold_w   (hold_w),
    .bus_data (bus_data),
    .bus_oe   (bus_oe),
    .rd_valid (rd_valid),
    .lane_err (lane_err)
);

// File: tb/pos_latch_readout_test.sv
`timescale 1ns/1ps
module pos_latch_readout_test;
    localparam int VDLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pos_in = 16'h0000;
    logic        inhibit = 1'b0;
    logic        msb_en_n = 1'b1;
    logic        lsb_en_n = 1'b1;

    logic [7:0]  n_data, n_oe;
    logic        n_valid, n_err;
    logic [15:0] w_data, w_oe;
    logic        w_valid, w_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pos_latch_readout #(.POS_W(16), .WIDE_BUS(1'b0), .VALID_DLY(VDLY)) uut (
        .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .inhibit(inhibit),
        .msb_en_n(msb_en_n), .lsb_en_n(lsb_en_n),
        .bus_data(n_data), .bus_oe(n_oe), .rd_valid(n_valid), .lane_err(n_err));

    pos_latch_readout #(.POS_W(16), .WIDE_BUS(1'b1), .VALID_DLY(VDLY)) uut_w (
        .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .inhibit(inhibit),
        .msb_en_n(msb_en_n), .lsb_en_n(lsb_en_n),
        .bus_data(w_data), .bus_oe(w_oe), .rd_valid(w_valid), .lane_err(w_err));

    // behavioural reference: held word and count of consecutive hold edges
    logic [15:0] m_word = 16'h0000;
    int          m_hold_edges = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_word       <= 16'h0000;
            m_hold_edges <= 0;
        end else if (!inhibit) begin
            m_word       <= pos_in;
            m_hold_edges <= 0;
        end else if (m_hold_edges < 1000) begin
            m_hold_edges <= m_hold_edges + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [7:0]  e_nd, e_no;
        logic        e_ne;
        logic [15:0] e_wd, e_wo;
        string       ntag;
        logic        e_valid;
        e_valid = (m_hold_edges >= VDLY);
        e_ne = 1'b0;
        if (msb_en_n == 1'b0 && lsb_en_n == 1'b0) begin
            e_nd = m_word[15:8]; e_no = 8'hFF; e_ne = 1'b1; ntag = "R8";
        end else if (msb_en_n == 1'b0) begin
            e_nd = m_word[15:8]; e_no = 8'hFF; ntag = "R6";
        end else if (lsb_en_n == 1'b0) begin
            e_nd = m_word[7:0];  e_no = 8'hFF; ntag = "R7";
        end else begin
            e_nd = 8'h00; e_no = 8'h00; ntag = "R10";
        end
        e_wd = 16'h0000; e_wo = 16'h0000;
        if (msb_en_n == 1'b0) begin e_wd[15:8] = m_word[15:8]; e_wo[15:8] = 8'hFF; end
        if (lsb_en_n == 1'b0) begin e_wd[7:0]  = m_word[7:0];  e_wo[7:0]  = 8'hFF; end
        check({ntag, " narrow data"}, {24'd0, n_data}, {24'd0, e_nd});
        check({ntag, " narrow oe"},   {24'd0, n_oe},   {24'd0, e_no});
        check("R8 narrow err", {31'd0, n_err}, {31'd0, e_ne});
        check("R9 wide data", {16'd0, w_data}, {16'd0, e_wd});
        check("R9 wide oe",   {16'd0, w_oe},   {16'd0, e_wo});
        check("R9 wide err",  {31'd0, w_err},  32'd0);
        check("R4 valid narrow", {31'd0, n_valid}, {31'd0, e_valid});
        check("R4 valid wide",   {31'd0, w_valid}, {31'd0, e_valid});
    endtask

    // apply inputs at a falling edge, then compare after the next rising edge
    task automatic cyc(input logic inh, input logic m_n, input logic l_n, input int inc);
        inhibit  = inh;
        msb_en_n = m_n;
        lsb_en_n = l_n;
        pos_in   = pos_in + 16'(inc);
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] snap;
        rst_n = 1'b0; msb_en_n = 1'b0; lsb_en_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state seen through the wide bus with both lanes enabled
        check("R1 reset word", {16'd0, w_data}, 32'd0);
        check("R1 reset valid", {31'd0, w_valid}, 32'd0);
        check("R1 reset valid narrow", {31'd0, n_valid}, 32'd0);
        rst_n = 1'b1;
        pos_in = 16'h1234;

        // tracking with every lane pattern
        for (int i = 0; i < 8; i++) cyc(1'b0, i[0], i[1], 7);
        cyc(1'b0, 1'b0, 1'b0, 3);
        check("R2 tracks live position", {16'd0, w_data}, {16'd0, pos_in});

        // long hold, read across the freezing edge, lanes alternating
        snap = pos_in;
        cyc(1'b1, 1'b0, 1'b1, 257);
        check("R4 not yet valid after one hold edge", {31'd0, w_valid}, 32'd0);
        cyc(1'b1, 1'b1, 1'b0, 257);
        check("R4 not yet valid after two hold edges", {31'd0, w_valid}, 32'd0);
        cyc(1'b1, 1'b0, 1'b0, 257);
        check("R4 valid after VALID_DLY hold edges", {31'd0, w_valid}, 32'd1);
        for (int i = 0; i < 40; i++) cyc(1'b1, i[0], ~i[0], 911);
        cyc(1'b1, 1'b0, 1'b0, 5);
        check("R3 word frozen through long hold", {16'd0, w_data}, {16'd0, snap});
        check("R4 valid held during hold", {31'd0, n_valid}, 32'd1);

        // release: live value loaded on the first edge
        cyc(1'b0, 1'b0, 1'b0, 77);
        check("R5 live value after release", {16'd0, w_data}, {16'd0, pos_in});
        check("R4 valid cleared after release", {31'd0, w_valid}, 32'd0);

        // short hold never raises valid
        cyc(1'b1, 1'b0, 1'b1, 9);
        cyc(1'b1, 1'b1, 1'b0, 9);
        check("R4 short hold stays invalid", {31'd0, w_valid}, 32'd0);
        cyc(1'b0, 1'b1, 1'b1, 9);
        check("R10 idle lanes narrow oe", {24'd0, n_oe}, 32'd0);

        // mixed stimulus
        for (int i = 0; i < 600; i++) begin
            logic inh_r;
            inh_r = ($urandom_range(0, 9) < 6);
            cyc(inh_r, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 3000)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule